// File: doc/BRIEF.md
# Rank-Counting Frame Sorter

The block collects one frame of time values, each with a small tag that travels alongside it, and emits the same values in ascending time order once the frame is closed. Times enter a linear chain of cells, one cell per cycle. Each arriving time carries a rank field. A cell that already holds a value compares it with the passing time. If the held value is smaller or equal, the passing rank is bumped. If the held value is larger, the held rank is bumped instead. The passing time settles in the first empty cell it reaches, so after the chain drains every held value carries its final, unique rank.

An end-of-frame pulse closes the frame. The block waits until no time is still moving along the chain, then turns the chain into a shift register. Each held entry that falls off the end is written into a storage array at the address given by its rank, and the entries are counted as they go. The array is then read from address 0 up to count−1, one word per cycle, and the final word is flagged. New input is refused from the end-of-frame pulse until the final word is presented.

Top module: `systolic_sorter`

## Requirements
- R1: After reset, in_ready is 1 and out_valid and out_last are 0.
- R2: For each frame the number of words output equals the number of times accepted, and out_time is non-decreasing from word to word.
- R3: Times that are equal leave in the order they were accepted (the earlier arrival first).
- R4: Each output word carries on out_tag the tag that was accepted together with that time.
- R5: out_last is 1 on the final word of a frame and on no other cycle; it is only ever 1 together with out_valid.
- R6: in_ready is 0 from the cycle after in_eof is taken (in_eof is taken on any clock edge where in_ready could be 1, or where the frame is full) until the final word; in_ready is 1 again in the cycle the final word is presented.
- R7: A frame holds at most N_CELLS times: after N_CELLS acceptances in_ready drops to 0, offered times are not taken, and in_eof still closes the frame.
- R8: A frame closed with no time accepted produces no output word, and in_ready returns to 1.
- R9: The words of one frame are presented on consecutive cycles, with no idle cycle between the first and the final word.
- R10: A time offered (in_valid and in_ready) in the same cycle as in_eof belongs to the frame being closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A time is offered this cycle |
| in_ready | output | 1 | The block takes the offered time this cycle |
| in_time | input | TIME_W | Time value to sort |
| in_tag | input | TAG_W | Payload that travels with the time |
| in_eof | input | 1 | Closes the current frame |
| out_valid | output | 1 | A sorted word is presented |
| out_time | output | TIME_W | Sorted time value |
| out_tag | output | TAG_W | Payload of the sorted time |
| out_last | output | 1 | Marks the final word of a frame |

## Verification
The bench builds the sorter with N_CELLS = 8, TIME_W = 8 and TAG_W = 4, so a full frame is reached with eight inputs and the capacity limit, the refusal of further times and the closing of a full frame all fall within a few dozen cycles. The tag is set to the arrival index, which makes the tie order among equal times and the pairing of tag with time visible at the output. Frames of one value, of all-equal values, in rising and falling order and with extreme values exercise every compare outcome in the cells, and an empty frame checks that the scatter pass alone produces nothing.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_FLUSH   = 2'd1,
        ST_SCATTER = 2'd2,
        ST_READ    = 2'd3
    } sort_state_e;

endpackage

// File: rtl/sort_cell.sv
module sort_cell #(
    parameter int TIME_W = 16,
    parameter int TAG_W  = 8,
    parameter int POS_W  = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           shift_en,
    input  logic [TIME_W+POS_W+TAG_W:0]    tok_i,
    output logic [TIME_W+POS_W+TAG_W:0]    tok_o,
    input  logic [TIME_W+POS_W+TAG_W:0]    slot_i,
    output logic [TIME_W+POS_W+TAG_W:0]    slot_o
);

    typedef struct packed {
        logic              occ;
        logic [TIME_W-1:0] tval;
        logic [POS_W-1:0]  pos;
        logic [TAG_W-1:0]  tag;
    } slot_t;

    typedef struct packed {
        logic              vld;
        logic [TIME_W-1:0] tval;
        logic [POS_W-1:0]  pos;
        logic [TAG_W-1:0]  tag;
    } tok_t;

    typedef struct packed {
        slot_t slot;
        tok_t  tok;
    } cell_t;

    cell_t r_d, r_q;
    tok_t  tin;

    always_comb begin
        tin      = tok_t'(tok_i);
        r_d      = r_q;
        r_d.tok  = '0;
        if (shift_en) begin
            r_d.slot = slot_t'(slot_i);
        end else if (tin.vld) begin
            if (!r_q.slot.occ) begin
                // empty cell keeps the first arrival with its counted rank
                r_d.slot.occ  = 1'b1;
                r_d.slot.tval = tin.tval;
                r_d.slot.pos  = tin.pos;
                r_d.slot.tag  = tin.tag;
            end else if (r_q.slot.tval <= tin.tval) begin
                // held value ranks ahead: passing time moves one place down
                r_d.tok     = tin;
                r_d.tok.pos = tin.pos + POS_W'(1);
            end else begin
                // passing time ranks ahead: held value moves one place down
                r_d.slot.pos = r_q.slot.pos + POS_W'(1);
                r_d.tok      = tin;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tok_o  = r_q.tok;
    assign slot_o = r_q.slot;

endmodule

// File: rtl/sort_ram.sv
module sort_ram #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [0:DEPTH-1];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_q <= mem_q[rd_addr];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
    import sorter_pkg::*;
#(
    parameter int N_CELLS = 32,
    parameter int POS_W   = 5,
    parameter int CNT_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_eof,
    input  logic             chain_busy,
    input  logic             scat_occ,
    input  logic [POS_W-1:0] scat_pos,
    output logic             in_ready,
    output logic             accept,
    output logic             shift_en,
    output logic             wr_en,
    output logic [POS_W-1:0] wr_addr,
    output logic             rd_en,
    output logic [POS_W-1:0] rd_addr,
    output logic             out_valid,
    output logic             out_last
);

    typedef struct packed {
        sort_state_e      st;
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] sh;
        logic [CNT_W-1:0] ent;
        logic [POS_W-1:0] ra;
        logic             ov;
        logic             ol;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  rd_last;

    always_comb begin
        c_d      = c_q;
        c_d.ov   = 1'b0;
        c_d.ol   = 1'b0;
        shift_en = 1'b0;
        wr_en    = 1'b0;
        wr_addr  = '0;
        rd_en    = 1'b0;
        rd_addr  = '0;
        rd_last  = 1'b0;
        in_ready = (c_q.st == ST_COLLECT) && (c_q.acc < CNT_W'(N_CELLS));
        accept   = in_valid && in_ready;

        unique case (c_q.st)
            ST_COLLECT: begin
                if (accept) begin
                    c_d.acc = c_q.acc + CNT_W'(1);
                end
                if (in_eof) begin
                    c_d.st  = ST_FLUSH;
                    c_d.acc = '0;
                end
            end
            ST_FLUSH: begin
                if (!chain_busy) begin
                    c_d.st  = ST_SCATTER;
                    c_d.sh  = '0;
                    c_d.ent = '0;
                end
            end
            ST_SCATTER: begin
                shift_en = 1'b1;
                wr_en    = scat_occ;
                wr_addr  = scat_pos;
                if (scat_occ) begin
                    c_d.ent = c_q.ent + CNT_W'(1);
                end
                c_d.sh = c_q.sh + CNT_W'(1);
                if (c_q.sh == CNT_W'(N_CELLS - 1)) begin
                    c_d.ra = '0;
                    if (c_d.ent == '0) begin
                        c_d.st = ST_COLLECT;
                    end else begin
                        c_d.st = ST_READ;
                    end
                end
            end
            ST_READ: begin
                rd_en   = 1'b1;
                rd_addr = c_q.ra;
                rd_last = (CNT_W'(c_q.ra) == (c_q.ent - CNT_W'(1)));
                c_d.ov  = 1'b1;
                c_d.ol  = rd_last;
                c_d.ra  = c_q.ra + POS_W'(1);
                if (rd_last) begin
                    c_d.st = ST_COLLECT;
                end
            end
            default: begin
                c_d.st = ST_COLLECT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_COLLECT;
        end else begin
            c_q <= c_d;
        end
    end

    assign out_valid = c_q.ov;
    assign out_last  = c_q.ol;

endmodule

// File: rtl/systolic_sorter.sv
module systolic_sorter #(
    parameter int N_CELLS = 32,
    parameter int TIME_W  = 16,
    parameter int TAG_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TIME_W-1:0] in_time,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              in_eof,
    output logic              out_valid,
    output logic [TIME_W-1:0] out_time,
    output logic [TAG_W-1:0]  out_tag,
    output logic              out_last
);

    localparam int POS_W  = (N_CELLS > 2) ? $clog2(N_CELLS) : 1;
    localparam int CNT_W  = $clog2(N_CELLS + 1);
    localparam int ENT_W  = 1 + TIME_W + POS_W + TAG_W;
    localparam int DATA_W = TIME_W + TAG_W;

    logic [ENT_W-1:0] tok_bus   [0:N_CELLS];
    logic [ENT_W-1:0] slot_bus  [0:N_CELLS-1];
    logic [ENT_W-1:0] shift_src [0:N_CELLS-1];
    logic [N_CELLS-1:0] busy_vec;

    logic             accept;
    logic             shift_en;
    logic             chain_busy;
    logic             scat_occ;
    logic [POS_W-1:0] scat_pos;
    logic [DATA_W-1:0] scat_data;
    logic             wr_en;
    logic [POS_W-1:0] wr_addr;
    logic             rd_en;
    logic [POS_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    // a new time enters the first cell with rank zero
    assign tok_bus[0] = accept ? {1'b1, in_time, POS_W'(0), in_tag} : '0;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_chain
        if (i == 0) begin : g_head
            assign shift_src[i] = '0;
        end else begin : g_body
            assign shift_src[i] = slot_bus[i-1];
        end

        sort_cell #(
            .TIME_W (TIME_W),
            .TAG_W  (TAG_W),
            .POS_W  (POS_W)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .tok_i    (tok_bus[i]),
            .tok_o    (tok_bus[i+1]),
            .slot_i   (shift_src[i]),
            .slot_o   (slot_bus[i])
        );

        // an idle token register is all zero, so any set bit means a time in flight
        assign busy_vec[i] = |tok_bus[i+1];
    end

    assign chain_busy = |busy_vec;

    // unpack the entry leaving the tail cell: {occ, time, rank, tag}
    assign scat_occ  = slot_bus[N_CELLS-1][ENT_W-1];
    assign scat_pos  = slot_bus[N_CELLS-1][POS_W+TAG_W-1:TAG_W];
    assign scat_data = {slot_bus[N_CELLS-1][ENT_W-2:POS_W+TAG_W],
                        slot_bus[N_CELLS-1][TAG_W-1:0]};

    sort_ctrl #(
        .N_CELLS (N_CELLS),
        .POS_W   (POS_W),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_eof     (in_eof),
        .chain_busy (chain_busy),
        .scat_occ   (scat_occ),
        .scat_pos   (scat_pos),
        .in_ready   (in_ready),
        .accept     (accept),
        .shift_en   (shift_en),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .out_valid  (out_valid),
        .out_last   (out_last)
    );

    sort_ram #(
        .DEPTH  (N_CELLS),
        .ADDR_W (POS_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (scat_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign out_time = rd_data[DATA_W-1:TAG_W];
    assign out_tag  = rd_data[TAG_W-1:0];

endmodule

// File: rtl/sorter_checker.sv
module sorter_checker #(
    parameter int TIME_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_eof,
    input logic              out_valid,
    input logic              out_last,
    input logic [TIME_W-1:0] out_time
);

    // R1: idle state right after reset
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (in_ready && !out_valid && !out_last));

    // R2: non-decreasing output inside a frame
    assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_time >= $past(out_time)));

    // R5: last flag only on a presented word
    assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R6: no input while a frame is closing
    assert_eof_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_eof && in_ready) |=> !in_ready);

    // R6: no input while non-final words are presented
    assert_read_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !in_ready);

    // R9: words of a frame are back to back
    assert_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    // R7: no acceptance is signalled together with a presented non-final word
    assert_no_take_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> !(out_valid && !out_last));

endmodule

bind systolic_sorter sorter_checker #(.TIME_W(TIME_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eof    (in_eof),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_time  (out_time)
);

// File: tb/sim_systolic_sorter.sv
module sim_systolic_sorter;

    localparam int CLK_PERIOD = 10;
    localparam int NC   = 8;
    localparam int TW   = 8;
    localparam int GW   = 4;
    localparam int ROWS = 6;

    localparam logic [7:0] TBL_T [0:ROWS-1][0:7] = '{
        '{8'd40, 8'd10, 8'd30, 8'd20, 8'd50, 8'd0,  8'd0,  8'd0},
        '{8'd7,  8'd7,  8'd3,  8'd7,  8'd3,  8'd200,8'd0,  8'd255},
        '{8'd99, 8'd0,  8'd0,  8'd0,  8'd0,  8'd0,  8'd0,  8'd0},
        '{8'd80, 8'd70, 8'd60, 8'd50, 8'd40, 8'd30, 8'd20, 8'd10},
        '{8'd1,  8'd2,  8'd3,  8'd4,  8'd5,  8'd6,  8'd7,  8'd8},
        '{8'd5,  8'd5,  8'd5,  8'd5,  8'd5,  8'd5,  8'd0,  8'd0}
    };
    localparam int TBL_LEN [0:ROWS-1] = '{5, 8, 1, 8, 8, 6};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [TW-1:0] in_time = '0;
    logic [GW-1:0] in_tag = '0;
    logic          in_eof = 1'b0;
    logic          out_valid;
    logic [TW-1:0] out_time;
    logic [GW-1:0] out_tag;
    logic          out_last;

    int checks = 0;
    int errors = 0;

    systolic_sorter #(.N_CELLS(NC), .TIME_W(TW), .TAG_W(GW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_time(in_time), .in_tag(in_tag), .in_eof(in_eof),
        .out_valid(out_valid), .out_time(out_time), .out_tag(out_tag),
        .out_last(out_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // output monitor
    int          cyc = 0;
    int          got_n = 0;
    int          last_cnt = 0;
    int          last_idx = -1;
    int          prev_cyc = 0;
    bit          gap = 1'b0;
    bit          ready_at_last = 1'b0;
    logic [TW-1:0] got_t [0:15];
    logic [GW-1:0] got_g [0:15];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && out_valid) begin
            if (got_n < 16) begin
                got_t[got_n] = out_time;
                got_g[got_n] = out_tag;
            end
            if (got_n > 0 && cyc != prev_cyc + 1) gap = 1'b1;
            prev_cyc = cyc;
            if (out_last) begin
                last_cnt = last_cnt + 1;
                last_idx = got_n;
                ready_at_last = in_ready;
            end
            got_n = got_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        got_n = 0; last_cnt = 0; last_idx = -1; gap = 1'b0; ready_at_last = 1'b0;
    endtask

    task automatic push(input logic [TW-1:0] t, input logic [GW-1:0] g, input bit with_eof);
        int w = 0;
        @(negedge clk);
        while (!in_ready && w < 1000) begin @(negedge clk); w++; end
        in_valid = 1'b1; in_time = t; in_tag = g; in_eof = with_eof;
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;
        if (with_eof) chk(in_ready == 1'b0, "R6", "in_ready after eof", in_ready, 0);
    endtask

    task automatic send_eof();
        @(negedge clk);
        in_eof = 1'b1;
        @(negedge clk);
        in_eof = 1'b0;
        chk(in_ready == 1'b0, "R6", "in_ready after eof", in_ready, 0);
    endtask

    task automatic wait_last();
        int w = 0;
        while (last_cnt == 0 && w < 400) begin @(negedge clk); w++; end
        repeat (3) @(negedge clk);
    endtask

    // stable ascending order computed from the stimulus, compared to the output
    task automatic verify(input logic [TW-1:0] t [0:15], input int n, input string req);
        logic [TW-1:0] et [0:15];
        logic [GW-1:0] eg [0:15];
        for (int i = 0; i < n; i++) begin et[i] = t[i]; eg[i] = GW'(i); end
        for (int i = 1; i < n; i++) begin
            for (int j = i; j > 0; j--) begin
                if (et[j-1] > et[j]) begin
                    logic [TW-1:0] tt; logic [GW-1:0] tg;
                    tt = et[j]; et[j] = et[j-1]; et[j-1] = tt;
                    tg = eg[j]; eg[j] = eg[j-1]; eg[j-1] = tg;
                end
            end
        end
        chk(got_n == n, "R2", "word count", got_n, n);
        for (int k = 0; k < n && k < got_n; k++) begin
            chk(got_t[k] == et[k], req, "time order", int'(got_t[k]), int'(et[k]));
            chk(got_g[k] == eg[k], "R4", "tag with time", int'(got_g[k]), int'(eg[k]));
        end
        chk(last_cnt == 1 && last_idx == n - 1, "R5", "last flag position", last_idx, n - 1);
        chk(!gap, "R9", "consecutive words", int'(gap), 0);
        chk(ready_at_last == 1'b1, "R6", "in_ready at final word", int'(ready_at_last), 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [TW-1:0] frame [0:15];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(out_last == 1'b0, "R1", "out_last after reset", out_last, 0);

        // table-driven frames: R2, R3 (rows with equal times), R4, R5, R9
        for (int r = 0; r < ROWS; r++) begin
            clear_mon();
            for (int i = 0; i < TBL_LEN[r]; i++) begin
                frame[i] = TBL_T[r][i];
                push(TBL_T[r][i], GW'(i), 1'b0);
            end
            send_eof();
            wait_last();
            verify(frame, TBL_LEN[r], (r == 1 || r == 5) ? "R3" : "R2");
        end

        // R10: last time offered together with the end-of-frame pulse
        clear_mon();
        frame[0] = 8'd30; frame[1] = 8'd10; frame[2] = 8'd20;
        push(8'd30, 4'd0, 1'b0);
        push(8'd10, 4'd1, 1'b0);
        push(8'd20, 4'd2, 1'b1);
        wait_last();
        verify(frame, 3, "R10");

        // R8: empty frame
        clear_mon();
        send_eof();
        repeat (NC + 20) @(negedge clk);
        chk(got_n == 0, "R8", "words from empty frame", got_n, 0);
        chk(in_ready == 1'b1, "R8", "in_ready after empty frame", in_ready, 1);

        // R7: capacity limit, extra offers refused, eof closes the full frame
        clear_mon();
        for (int i = 0; i < NC; i++) begin
            frame[i] = TW'(9 - i);
            push(TW'(9 - i), GW'(i), 1'b0);
        end
        chk(in_ready == 1'b0, "R7", "in_ready when full", in_ready, 0);
        in_valid = 1'b1; in_time = 8'd0; in_tag = 4'd15;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R7", "in_ready still low", in_ready, 0);
        send_eof();
        wait_last();
        verify(frame, NC, "R7");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule